// File: doc/BRIEF.md
# Paravirtual I/O Legacy Register File

This block is the device-side register window of a paravirtual I/O function that uses the old I/O-space layout. A host-side bus master reaches it through a word-wide register bus: a byte address, four byte enables, write data with a write strobe, and a read strobe whose data returns one cycle later. The window holds a fixed host feature word, a guest feature word, a queue selector, a per-queue page frame number, a read-only queue size, a doorbell, an 8-bit device status, and a read-to-clear interrupt status byte. When message-signalled interrupts are enabled, two 16-bit vector registers are also present: one for configuration changes and one for each queue.

The per-queue frame number and queue vector are banked. The register at the fixed offset always shows the entry of the queue chosen by the selector. The selected queue's ring base address (frame number shifted left by 12) is driven out for the ring engine. A doorbell write does not store anything. It produces a one-cycle pulse that carries the written queue index. Addresses above the common area go to a device-specific window. Its start moves from byte 20 to byte 24 when vectors are enabled, and the block passes each access through with an offset relative to that start.

Top module: `pvio_regfile`

## Requirements
- R1: After reset the following hold. Offset 0 reads HOST_FEATURES. Offset 4 (guest features), the device status (byte lane 2 of offset 16), the interrupt status (byte lane 3 of offset 16) and the queue select (upper half of offset 12) all read 0. Every vector reads 0xFFFF.
- R2: Guest features (offset 4) are written per byte: lane n updates bits 8n+7..8n only when bus_be[n] is set. Writes to host features (offset 0) and to the queue size (lower half of offset 12) are ignored.
- R3: The queue select is the upper 16 bits of offset 12 and is written through lanes 2 and 3. Offset 8 reads and writes, per byte, the page frame number of the selected queue, and each queue keeps its own value. ring_base equals that frame number shifted left by 12 bits.
- R4: The queue size (lower 16 bits of offset 12) reads QUEUE_SIZE when the select is below NUM_QUEUES and 0 otherwise. For an out-of-range select, frame number writes are ignored, offset 8 reads 0, and ring_base is 0.
- R5: A write to offset 16 with bus_be[0] or bus_be[1] set raises notify_valid for exactly the cycle after the write. notify_queue then holds the lower 16 bits of write data, with disabled bytes taken as 0.
- R6: The interrupt status byte is lane 3 of offset 16. Bit 0 is set by irq_queue_set and bit 1 by irq_config_set. A read of offset 16 with bus_be[3] set returns the current value and clears it. A read without bus_be[3] does not clear it.
- R7: A set event in the same cycle as a clearing read is not lost. The read returns the old value and the new bit is still set afterwards.
- R8: The device status is lane 2 of offset 16. Writing 0 there clears the guest features, all frame numbers and the interrupt status, and sets every vector to 0xFFFF. The queue select is kept. A nonzero write is stored and read back.
- R9: With msix_en high, offset 20 holds the configuration vector in bits 15..0 and the selected queue's vector in bits 31..16, each written per byte. For an out-of-range select the queue vector reads 0xFFFF and ignores writes.
- R10: The device window starts at byte 24 with msix_en high and at byte 20 otherwise. An access at or above the start drives dev_rd or dev_wr with dev_offset = address minus start. Its read returns dev_rdata.
- R11: bus_rdata changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msix_en | input | 1 | Vector registers present; moves the device window start |
| bus_addr | input | ADDR_W | Byte address of the access (word aligned) |
| bus_be | input | 4 | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_queue_set | input | 1 | Sets interrupt status bit 0 |
| irq_config_set | input | 1 | Sets interrupt status bit 1 |
| notify_valid | output | 1 | One-cycle doorbell pulse |
| notify_queue | output | 16 | Queue index of the doorbell |
| guest_features | output | 32 | Guest feature word |
| dev_status | output | 8 | Device status byte |
| ring_base | output | 44 | Ring base address of the selected queue |
| dev_wr | output | 1 | Write into the device window |
| dev_rd | output | 1 | Read from the device window |
| dev_offset | output | ADDR_W | Offset within the device window |
| dev_be | output | 4 | Byte enables toward the device window |
| dev_wdata | output | 32 | Write data toward the device window |
| dev_rdata | input | 32 | Read data from the device window |

## Verification
Two functions of this block can land in the same cycle: a clearing read of the interrupt status and a set event from the device. The bench sets bit 0 first. It then issues the clearing read in the same cycle as a configuration-change pulse. The data returned must show only the old bit 0. A second read must show bit 1 still set, and a third read must show zero. The other case is a device reset by status write while interrupt bits are pending. All banked state must return to its reset values, and the selector must be unchanged.

// File: rtl/pvio_pkg.sv
package pvio_pkg;
  // word indices of the common area (byte offset / 4)
  localparam int unsigned W_HOSTF  = 0;
  localparam int unsigned W_GUESTF = 1;
  localparam int unsigned W_PFN    = 2;
  localparam int unsigned W_QNUM   = 3;
  localparam int unsigned W_CTRL   = 4;
  localparam int unsigned W_VEC    = 5;

  localparam int unsigned DEV_START_VEC   = 24;
  localparam int unsigned DEV_START_PLAIN = 20;

  localparam int unsigned RING_SHIFT = 12;
  localparam logic [15:0] NO_VECTOR  = 16'hFFFF;

  function automatic logic [31:0] merge32(input logic [31:0] old_v,
                                          input logic [31:0] new_v,
                                          input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [15:0] merge16(input logic [15:0] old_v,
                                          input logic [15:0] new_v,
                                          input logic [1:0]  be);
    logic [15:0] r;
    for (int b = 0; b < 2; b++)
      r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  function automatic logic [43:0] ring_addr(input logic [31:0] pfn);
    return {pfn, 12'h000};
  endfunction
endpackage

// File: rtl/pvio_queue_bank.sv
module pvio_queue_bank
  import pvio_pkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int SEL_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic [SEL_W-1:0] sel,
  input  logic             pfn_we,
  input  logic [3:0]       pfn_be,
  input  logic [31:0]      pfn_wdata,
  input  logic             vec_we,
  input  logic [1:0]       vec_be,
  input  logic [15:0]      vec_wdata,
  output logic             sel_valid,
  output logic [31:0]      pfn_sel,
  output logic [15:0]      vec_sel
);
  logic [31:0] pfn_q [NUM_QUEUES];
  logic [15:0] vec_q [NUM_QUEUES];

  assign sel_valid = 32'(sel) < NUM_QUEUES;

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_q
    logic hit;
    assign hit = (sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pfn_q[g] <= '0;
        vec_q[g] <= NO_VECTOR;
      end else if (soft_clr) begin
        pfn_q[g] <= '0;
        vec_q[g] <= NO_VECTOR;
      end else begin
        if (pfn_we && hit) pfn_q[g] <= merge32(pfn_q[g], pfn_wdata, pfn_be);
        if (vec_we && hit) vec_q[g] <= merge16(vec_q[g], vec_wdata, vec_be);
      end
    end
  end

  always_comb begin
    pfn_sel = '0;
    vec_sel = NO_VECTOR;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (sel == SEL_W'(i)) begin
        pfn_sel = pfn_q[i];
        vec_sel = vec_q[i];
      end
    end
  end
endmodule

// File: rtl/pvio_isr.sv
module pvio_isr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       set_queue,
  input  logic       set_cfg,
  input  logic       rd_clr,
  output logic [7:0] isr
);
  logic [1:0] flags;
  logic [1:0] kept;

  // clearing read and soft reset drop old bits; new events always land
  assign kept = (soft_clr || rd_clr) ? 2'b00 : flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 2'b00;
    else        flags <= kept | {set_cfg, set_queue};
  end

  assign isr = {6'b0, flags};
endmodule

// File: rtl/pvio_regfile.sv
module pvio_regfile
  import pvio_pkg::*;
#(
  parameter int          NUM_QUEUES    = 4,
  parameter int          QUEUE_SIZE    = 256,
  parameter logic [31:0] HOST_FEATURES = 32'h0100_0031,
  parameter int          ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msix_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              irq_queue_set,
  input  logic              irq_config_set,
  output logic              notify_valid,
  output logic [15:0]       notify_queue,
  output logic [31:0]       guest_features,
  output logic [7:0]        dev_status,
  output logic [43:0]       ring_base,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [ADDR_W-1:0] dev_offset,
  output logic [3:0]        dev_be,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] dev_start;
  logic              in_dev;
  logic              hit_guestf, hit_pfn, hit_qnum, hit_ctrl, hit_vec;

  assign word      = bus_addr[ADDR_W-1:2];
  assign dev_start = msix_en ? ADDR_W'(DEV_START_VEC) : ADDR_W'(DEV_START_PLAIN);
  assign in_dev    = bus_addr >= dev_start;

  assign hit_guestf = !in_dev && (word == WORD_W'(W_GUESTF));
  assign hit_pfn    = !in_dev && (word == WORD_W'(W_PFN));
  assign hit_qnum   = !in_dev && (word == WORD_W'(W_QNUM));
  assign hit_ctrl   = !in_dev && (word == WORD_W'(W_CTRL));
  assign hit_vec    = !in_dev && (word == WORD_W'(W_VEC));

  // named internal events, observed by the checker
  logic ev_notify, ev_status_wr, ev_soft_rst, ev_isr_clr;
  assign ev_notify    = bus_wr && hit_ctrl && (bus_be[0] || bus_be[1]);
  assign ev_status_wr = bus_wr && hit_ctrl && bus_be[2];
  assign ev_soft_rst  = ev_status_wr && (bus_wdata[23:16] == 8'h00);
  assign ev_isr_clr   = bus_rd && hit_ctrl && bus_be[3];

  logic [15:0] qsel;
  logic [15:0] cfg_vec;
  logic        sel_valid;
  logic [31:0] pfn_sel;
  logic [15:0] vec_sel;
  logic [7:0]  isr;

  pvio_queue_bank #(.NUM_QUEUES(NUM_QUEUES), .SEL_W(16)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (ev_soft_rst),
    .sel       (qsel),
    .pfn_we    (bus_wr && hit_pfn),
    .pfn_be    (bus_be),
    .pfn_wdata (bus_wdata),
    .vec_we    (bus_wr && hit_vec),
    .vec_be    (bus_be[3:2]),
    .vec_wdata (bus_wdata[31:16]),
    .sel_valid (sel_valid),
    .pfn_sel   (pfn_sel),
    .vec_sel   (vec_sel)
  );

  pvio_isr isr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (ev_soft_rst),
    .set_queue (irq_queue_set),
    .set_cfg   (irq_config_set),
    .rd_clr    (ev_isr_clr),
    .isr       (isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_features <= '0;
      qsel           <= '0;
      cfg_vec        <= NO_VECTOR;
      dev_status     <= '0;
      notify_valid   <= 1'b0;
      notify_queue   <= '0;
    end else begin
      notify_valid <= ev_notify;
      if (ev_notify)
        notify_queue <= merge16(16'h0000, bus_wdata[15:0], bus_be[1:0]);
      if (ev_status_wr) dev_status <= bus_wdata[23:16];
      if (bus_wr && hit_qnum)
        qsel <= merge16(qsel, bus_wdata[31:16], bus_be[3:2]);
      if (ev_soft_rst) begin
        guest_features <= '0;
        cfg_vec        <= NO_VECTOR;
      end else begin
        if (bus_wr && hit_guestf)
          guest_features <= merge32(guest_features, bus_wdata, bus_be);
        if (bus_wr && hit_vec)
          cfg_vec <= merge16(cfg_vec, bus_wdata[15:0], bus_be[1:0]);
      end
    end
  end

  logic [15:0] qsize;
  logic [31:0] rd_word;
  assign qsize = sel_valid ? 16'(QUEUE_SIZE) : 16'h0000;

  always_comb begin
    rd_word = '0;
    if (in_dev) rd_word = dev_rdata;
    else begin
      case (32'(word))
        W_HOSTF:  rd_word = HOST_FEATURES;
        W_GUESTF: rd_word = guest_features;
        W_PFN:    rd_word = pfn_sel;
        W_QNUM:   rd_word = {qsel, qsize};
        W_CTRL:   rd_word = {isr, dev_status, 16'h0000};
        W_VEC:    rd_word = {vec_sel, cfg_vec};
        default:  rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  assign ring_base  = ring_addr(pfn_sel);
  assign dev_wr     = bus_wr && in_dev;
  assign dev_rd     = bus_rd && in_dev;
  assign dev_offset = bus_addr - dev_start;
  assign dev_be     = bus_be;
  assign dev_wdata  = bus_wdata;
endmodule

// File: rtl/pvio_regfile_chk.sv
module pvio_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        bus_rd,
  input logic [31:0] bus_rdata,
  input logic        irq_queue_set,
  input logic        irq_config_set,
  input logic        notify_valid,
  input logic [15:0] notify_queue,
  input logic [31:0] guest_features,
  input logic [43:0] ring_base,
  input logic        ev_notify,
  input logic        ev_isr_clr,
  input logic        ev_soft_rst,
  input logic        sel_valid,
  input logic [7:0]  isr
);
  assert_notify_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_notify |=> notify_valid);
  assert_notify_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_notify |=> !notify_valid);
  assert_notify_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_notify && bus_be[1:0] == 2'b11) |=> notify_queue == $past(bus_wdata[15:0]));
  assert_isr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_isr_clr && !irq_queue_set && !irq_config_set) |=> isr == 8'h00);
  assert_queue_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_queue_set |=> isr[0]);
  assert_cfg_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_config_set |=> isr[1]);
  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> guest_features == 32'h0);
  assert_oob_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> ring_base == 44'h0);
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind pvio_regfile pvio_regfile_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_be         (bus_be),
  .bus_wdata      (bus_wdata),
  .bus_rd         (bus_rd),
  .bus_rdata      (bus_rdata),
  .irq_queue_set  (irq_queue_set),
  .irq_config_set (irq_config_set),
  .notify_valid   (notify_valid),
  .notify_queue   (notify_queue),
  .guest_features (guest_features),
  .ring_base      (ring_base),
  .ev_notify      (ev_notify),
  .ev_isr_clr     (ev_isr_clr),
  .ev_soft_rst    (ev_soft_rst),
  .sel_valid      (sel_valid),
  .isr            (isr)
);

// File: tb/pvio_regfile_tb_top.sv
module pvio_regfile_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NQ         = 4;
  localparam int          QSZ        = 256;
  localparam logic [31:0] HOSTF      = 32'hC0DE_F00D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msix_en = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_queue_set = 1'b0;
  logic        irq_config_set = 1'b0;
  logic        notify_valid;
  logic [15:0] notify_queue;
  logic [31:0] guest_features;
  logic [7:0]  dev_status;
  logic [43:0] ring_base;
  logic        dev_wr, dev_rd;
  logic [7:0]  dev_offset;
  logic [3:0]  dev_be;
  logic [31:0] dev_wdata;
  logic [31:0] dev_rdata;

  int n_chk = 0;
  int n_bad = 0;

  assign dev_rdata = 32'hA5A5_0000 | {24'h0, dev_offset};

  always #(CLK_PERIOD/2) clk = ~clk;

  pvio_regfile #(.NUM_QUEUES(NQ), .QUEUE_SIZE(QSZ), .HOST_FEATURES(HOSTF), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .msix_en(msix_en), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_queue_set(irq_queue_set), .irq_config_set(irq_config_set),
    .notify_valid(notify_valid), .notify_queue(notify_queue),
    .guest_features(guest_features), .dev_status(dev_status), .ring_base(ring_base),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_offset(dev_offset), .dev_be(dev_be),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0;
    d = bus_rdata;
  endtask

  task automatic irq(input logic q, input logic c);
    @(negedge clk);
    irq_queue_set = q; irq_config_set = c;
    @(negedge clk);
    irq_queue_set = 1'b0; irq_config_set = 1'b0;
  endtask

  function automatic logic [31:0] pfn_of(input int q);
    return 32'h100 + 32'(q) * 32'h1011;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'd0, 4'hF, d);  check("R1 host features", d, HOSTF);
    rd(8'd4, 4'hF, d);  check("R1 guest features", d, 0);
    rd(8'd16, 4'h4, d); check("R1 status and isr", d, 0);
    rd(8'd12, 4'hF, d); check("R1 select and size", d, {16'h0, 16'(QSZ)});
    rd(8'd20, 4'hF, d); check("R1 vectors", d, 32'hFFFF_FFFF);

    // R2 byte-enabled guest features, read-only words ignored
    wr(8'd4, 4'b0101, 32'h1122_3344);
    rd(8'd4, 4'hF, d);  check("R2 guest byte enables", d, 32'h0022_0044);
    check("R2 guest output", guest_features, 32'h0022_0044);
    wr(8'd0, 4'hF, 32'h0);
    rd(8'd0, 4'hF, d);  check("R2 host write ignored", d, HOSTF);
    wr(8'd12, 4'b0011, 32'h0000_FFFF);
    rd(8'd12, 4'hF, d); check("R2 size write ignored", d, {16'h0, 16'(QSZ)});

    // R3 R4 R9 sweep of selects, including out-of-range ones
    for (int q = 0; q < NQ + 2; q++) begin
      wr(8'd12, 4'b1100, {16'(q), 16'h0});
      wr(8'd8, 4'hF, pfn_of(q));
      wr(8'd20, 4'b1100, {16'h40 + 16'(q), 16'h0});
    end
    for (int q = 0; q < NQ + 2; q++) begin
      logic [31:0] ep;
      ep = (q < NQ) ? pfn_of(q) : 32'h0;
      wr(8'd12, 4'b1100, {16'(q), 16'h0});
      rd(8'd8, 4'hF, d);  check($sformatf("R3 R4 pfn q%0d", q), d, ep);
      check($sformatf("R3 ring base q%0d", q), ring_base, {ep, 12'h0});
      rd(8'd12, 4'hF, d);
      check($sformatf("R4 size q%0d", q), d, {16'(q), (q < NQ) ? 16'(QSZ) : 16'h0});
      rd(8'd20, 4'hF, d);
      check($sformatf("R9 queue vector q%0d", q), d,
            {(q < NQ) ? 16'h40 + 16'(q) : 16'hFFFF, 16'hFFFF});
    end
    wr(8'd12, 4'b1100, 32'h0001_0000);
    wr(8'd8, 4'b0010, 32'h0000_AB00);
    rd(8'd8, 4'hF, d);  check("R3 pfn byte enable", d, 32'h0000_AB11);
    wr(8'd20, 4'b0011, 32'h0000_0007);
    rd(8'd20, 4'hF, d); check("R9 config vector", d, 32'h0041_0007);

    // R5 doorbell
    wr(8'd16, 4'b0011, 32'h0000_0002);
    check("R5 notify pulse", notify_valid, 1);
    check("R5 notify index", notify_queue, 16'd2);
    @(negedge clk);
    check("R5 pulse one cycle", notify_valid, 0);
    wr(8'd16, 4'b0001, 32'h0000_FF05);
    check("R5 partial index", notify_queue, 16'h0005);
    wr(8'd16, 4'b0011, 32'h0000_0009);
    check("R5 out-of-range index", {notify_valid, notify_queue}, {1'b1, 16'h0009});
    rd(8'd8, 4'hF, d);  check("R5 notify stores nothing", d, 32'h0000_AB11);

    // R6 read-to-clear
    irq(1'b1, 1'b0);
    rd(8'd16, 4'h4, d); check("R6 read without lane3", d[31:24], 8'h01);
    rd(8'd16, 4'h8, d); check("R6 isr queue bit", d[31:24], 8'h01);
    rd(8'd16, 4'h8, d); check("R6 isr cleared", d[31:24], 8'h00);
    irq(1'b0, 1'b1);
    rd(8'd16, 4'h8, d); check("R6 isr config bit", d[31:24], 8'h02);

    // R7 set in the same cycle as a clearing read
    irq(1'b1, 1'b0);
    @(negedge clk);
    bus_addr = 8'd16; bus_be = 4'h8; bus_rd = 1'b1; irq_config_set = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = '0; irq_config_set = 1'b0;
    check("R7 read returns old", bus_rdata[31:24], 8'h01);
    rd(8'd16, 4'h8, d); check("R7 new bit kept", d[31:24], 8'h02);
    rd(8'd16, 4'h8, d); check("R7 then cleared", d[31:24], 8'h00);

    // R8 status and device reset
    wr(8'd16, 4'b0100, 32'h0007_0000);
    rd(8'd16, 4'h4, d); check("R8 status stored", d[23:16], 8'h07);
    check("R8 status output", dev_status, 8'h07);
    wr(8'd12, 4'b1100, 32'h0002_0000);
    irq(1'b1, 1'b1);
    wr(8'd16, 4'b0100, 32'h0000_0000);
    rd(8'd4, 4'hF, d);  check("R8 guest cleared", d, 0);
    rd(8'd12, 4'hF, d); check("R8 select kept", d, {16'd2, 16'(QSZ)});
    rd(8'd8, 4'hF, d);  check("R8 pfn cleared", d, 0);
    rd(8'd20, 4'hF, d); check("R8 vectors restored", d, 32'hFFFF_FFFF);
    rd(8'd16, 4'hC, d); check("R8 isr and status cleared", d[31:16], 16'h0000);

    // R10 device window placement
    rd(8'd24, 4'hF, d); check("R10 window start vec on", d, 32'hA5A5_0000);
    rd(8'd28, 4'hF, d); check("R10 window offset vec on", d, 32'hA5A5_0004);
    @(negedge clk);
    bus_addr = 8'd28; bus_be = 4'h3; bus_wdata = 32'h0BAD_CAFE; bus_wr = 1'b1;
    #1;
    check("R10 window write", {dev_wr, dev_offset, dev_be, dev_wdata},
          {1'b1, 8'd4, 4'h3, 32'h0BAD_CAFE});
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    msix_en = 1'b0;
    rd(8'd20, 4'hF, d); check("R10 window start vec off", d, 32'hA5A5_0000);
    rd(8'd24, 4'hF, d); check("R10 window offset vec off", d, 32'hA5A5_0004);
    rd(8'd16, 4'h4, d); check("R10 common area intact", d, 0);
    msix_en = 1'b1;

    // R11 read data held between reads
    rd(8'd0, 4'hF, held);
    wr(8'd4, 4'hF, 32'h1234_5678);
    repeat (3) @(negedge clk);
    check("R11 rdata held", bus_rdata, HOSTF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule